// File: doc/BRIEF.md
# Synchronous DRAM Command Sequencer

This block sits on the host side of a four-bank synchronous DRAM. After reset it runs a short start-up sequence: a precharge of every bank, then a load of the device's mode register. It then serves single-word read and write requests from a simple request port. For each request it decides whether the addressed row is already open. It reuses the open row, closes a different row first, or opens the row in an idle bank. It then issues the column command, with auto-precharge when the request asks for it. All device timing limits are given in nanoseconds as parameters and are rounded up to whole clock cycles.

Refresh is scheduled from a budget of REF_COUNT refreshes per REF_WINDOW_NS. When a refresh falls due it takes priority over requests. Any open banks are closed with one precharge-all, the refresh is issued, and the next command waits a full row cycle. A request stays on the port until `req_ack` pulses. That pulse appears in the same cycle as its read or write command on the device pins.

With default parameters (5 ns clock), the cycle counts are as follows: activate to column 4, precharge 4, active time 9, row cycle 14, activate to activate across banks 4, mode-set gap 2, write recovery 2, and refresh interval 3125.

Top module: `sdram_seq`

## Requirements
- R1: Commands appear on {cs_n,ras_n,cas_n,we_n} with these codes: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode set 0000, no-operation 0111. No-operation is driven in every cycle without a command. `req_ack` is high only in the cycle of a read or write command.
- R2: While reset is held, cs_n is 1, and req_ack and init_done are 0. The first clock after reset release issues a precharge with addr[10]=1 (all banks). init_done is 1 from the mode-set cycle on and stays 1.
- R3: The mode set comes RP cycles after the start-up precharge, with ba=0 and addr=0x030: burst length 1 (bits 2:0 = 000), sequential (bit 3 = 0), latency 3 (bits 6:4 = 011), other bits 0. No command follows a mode set by fewer than MRD cycles.
- R4: A read or write to a bank comes at least RCD cycles after that bank's activate. It carries ba = request bank and addr[8:0] = request column, and addr[10] = request auto-precharge flag.
- R5: Activates are at least RRD cycles apart across banks and at least RC cycles apart on one bank. An activate comes at least RP cycles after the precharge of its bank. Its addr carries the request row.
- R6: A precharge comes at least RAS cycles after the bank's activate and at least WR cycles after the last write to that bank. A single-bank precharge has addr[10]=0.
- R7: A request to the row already open in its bank is served with no activate and no precharge.
- R8: A request to a bank holding a different open row issues one precharge of that bank, then one activate, then the column command.
- R9: A refresh falls due every REFI cycles. Open banks are first closed by one precharge-all. The refresh is issued only with all banks closed. No command follows a refresh by fewer than RC cycles. Idle refreshes are exactly REFI cycles apart.
- R10: An auto-precharge column command closes its bank, so the next access to it activates without a precharge. That activate comes no earlier than RP plus WR cycles after a write, or RP plus 1 cycle after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present and held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Close the row after this access |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 12 | Row of the request |
| req_col | input | 9 | Column of the request |
| req_ack | output | 1 | Request taken; column command on the pins this cycle |
| init_done | output | 1 | Start-up sequence finished |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Row, column or mode value; bit 10 is the precharge flag |

## Verification
The assertions count cycles from commands seen on the device pins and assume those pins are driven only by this block. They also assume a request stays stable until its acknowledge and that reset starts every run. The stimulus holds each request until `req_ack` and changes it half a cycle later, so a request is never issued twice. It runs the directed accesses long before the first refresh falls due, so the hit, miss and closed-bank counts are not disturbed by a refresh. Refresh spacing is measured only once the port is idle.

// File: rtl/sdram_seq.sv
module sdram_seq #(
  parameter int CLK_NS        = 5,
  parameter int T_RCD_NS      = 20,
  parameter int T_RP_NS       = 20,
  parameter int T_RAS_NS      = 45,
  parameter int T_RC_NS       = 70,
  parameter int T_RRD_NS      = 20,
  parameter int MRD_CYC       = 2,
  parameter int WR_CYC        = 2,
  parameter int CAS_LAT       = 3,
  parameter int REF_WINDOW_NS = 64_000_000,
  parameter int REF_COUNT     = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_ap,
  input  logic [1:0]  req_bank,
  input  logic [11:0] req_row,
  input  logic [8:0]  req_col,
  output logic        req_ack,
  output logic        init_done,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [11:0] addr
);
  localparam int RCD  = (T_RCD_NS + CLK_NS - 1) / CLK_NS;
  localparam int RP   = (T_RP_NS  + CLK_NS - 1) / CLK_NS;
  localparam int RAS  = (T_RAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int RC   = (T_RC_NS  + CLK_NS - 1) / CLK_NS;
  localparam int RRD  = (T_RRD_NS + CLK_NS - 1) / CLK_NS;
  localparam int REFI = REF_WINDOW_NS / REF_COUNT / CLK_NS;
  localparam int TW   = $clog2(RC + RAS + RP + RCD + RRD + WR_CYC + MRD_CYC + 2);
  localparam int RW   = $clog2(REFI + 1);
  localparam logic [11:0] MODE = {5'b00000, 3'(CAS_LAT), 1'b0, 3'b000};
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;

  logic [1:0]    phase;
  logic [TW-1:0] gwait, c_rrd;
  logic [TW-1:0] c_rcd [4], c_ras [4], c_rc [4], c_rp [4], c_wr [4];
  logic [3:0]    openb;
  logic [11:0]   orow [4];
  logic [RW-1:0] ref_cnt;
  logic          ref_pend;
  logic          pre_ok_all, idle_all;
  logic          do_act, do_pre, do_pall, do_col, do_ref, do_mrs;

  wire [1:0] b   = req_bank;
  wire       hit = openb[b] && (orow[b] == req_row);
  assign init_done = (phase == 2'd2);

  always_comb begin
    {do_act, do_pre, do_pall, do_col, do_ref, do_mrs} = '0;
    pre_ok_all = 1'b1;
    idle_all   = 1'b1;
    for (int i = 0; i < 4; i++) begin
      pre_ok_all = pre_ok_all && (c_ras[i] == 0) && (c_wr[i] == 0);
      idle_all   = idle_all && (c_rp[i] == 0) && (c_rc[i] == 0);
    end
    if (phase == 2'd0) do_pall = 1'b1;
    else if (gwait == 0) begin
      if (phase == 2'd1) do_mrs = 1'b1;
      else if (ref_pend) begin
        if (openb != 0) do_pall = pre_ok_all;
        else            do_ref  = idle_all;
      end else if (req_valid) begin
        if (hit)            do_col = (c_rcd[b] == 0) && (!req_ap || c_ras[b] == 0);
        else if (openb[b])  do_pre = (c_ras[b] == 0) && (c_wr[b] == 0);
        else                do_act = (c_rp[b] == 0) && (c_rc[b] == 0) && (c_rrd == 0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 2'd0; gwait <= '0; c_rrd <= '0; openb <= '0;
      ref_cnt <= '0; ref_pend <= 1'b0; req_ack <= 1'b0;
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111; ba <= '0; addr <= '0;
      for (int i = 0; i < 4; i++) begin
        c_rcd[i] <= '0; c_ras[i] <= '0; c_rc[i] <= '0;
        c_rp[i] <= '0; c_wr[i] <= '0; orow[i] <= '0;
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (c_rcd[i] != 0) c_rcd[i] <= c_rcd[i] - 1'b1;
        if (c_ras[i] != 0) c_ras[i] <= c_ras[i] - 1'b1;
        if (c_rc[i]  != 0) c_rc[i]  <= c_rc[i]  - 1'b1;
        if (c_rp[i]  != 0) c_rp[i]  <= c_rp[i]  - 1'b1;
        if (c_wr[i]  != 0) c_wr[i]  <= c_wr[i]  - 1'b1;
      end
      if (c_rrd != 0) c_rrd <= c_rrd - 1'b1;
      if (gwait != 0) gwait <= gwait - 1'b1;
      {cs_n, ras_n, cas_n, we_n} <= C_NOP;
      req_ack <= 1'b0;

      if (do_pall) begin
        {cs_n, ras_n, cas_n, we_n} <= C_PRE;
        addr  <= 12'h400;
        openb <= '0;
        for (int i = 0; i < 4; i++) c_rp[i] <= TW'(RP - 1);
        if (phase == 2'd0) begin phase <= 2'd1; gwait <= TW'(RP - 1); end
      end
      if (do_mrs) begin
        {cs_n, ras_n, cas_n, we_n} <= C_MRS;
        ba <= 2'd0; addr <= MODE; phase <= 2'd2; gwait <= TW'(MRD_CYC - 1);
      end
      if (do_ref) begin
        {cs_n, ras_n, cas_n, we_n} <= C_REF;
        gwait <= TW'(RC - 1); ref_pend <= 1'b0;
      end
      if (do_act) begin
        {cs_n, ras_n, cas_n, we_n} <= C_ACT;
        ba <= b; addr <= req_row; openb[b] <= 1'b1; orow[b] <= req_row;
        c_rcd[b] <= TW'(RCD - 1); c_ras[b] <= TW'(RAS - 1);
        c_rc[b] <= TW'(RC - 1); c_rrd <= TW'(RRD - 1);
      end
      if (do_pre) begin
        {cs_n, ras_n, cas_n, we_n} <= C_PRE;
        ba <= b; addr <= 12'h000; openb[b] <= 1'b0; c_rp[b] <= TW'(RP - 1);
      end
      if (do_col) begin
        {cs_n, ras_n, cas_n, we_n} <= req_write ? C_WR : C_RD;
        ba <= b; addr <= {1'b0, req_ap, 1'b0, req_col}; req_ack <= 1'b1;
        if (req_write) c_wr[b] <= TW'(WR_CYC - 1);
        if (req_ap) begin
          openb[b] <= 1'b0;
          c_rp[b]  <= req_write ? TW'(RP - 1 + WR_CYC) : TW'(RP);
        end
      end

      if (ref_cnt == RW'(REFI - 1)) begin
        ref_cnt <= '0; ref_pend <= 1'b1;
      end else ref_cnt <= ref_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int CLK_NS   = 5,
  parameter int T_RCD_NS = 20,
  parameter int T_RRD_NS = 20,
  parameter int MRD_CYC  = 2,
  parameter int WR_CYC   = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [11:0] addr,
  input logic        req_ack,
  input logic        init_done
);
  localparam int RCD = (T_RCD_NS + CLK_NS - 1) / CLK_NS;
  localparam int RRD = (T_RRD_NS + CLK_NS - 1) / CLK_NS;

  wire [3:0] cmd    = {cs_n, ras_n, cas_n, we_n};
  wire       is_act = (cmd == 4'b0011);
  wire       is_col = (cmd[3:1] == 3'b010);
  wire       is_wr  = (cmd == 4'b0100);
  wire       is_pre = (cmd == 4'b0010);
  wire       is_ref = (cmd == 4'b0001);
  wire       is_mrs = (cmd == 4'b0000);
  wire       is_any = !cs_n && (cmd != 4'b0111);

  logic [15:0] s_act [4], s_wr [4];
  logic [15:0] s_any_act, s_mrs;
  logic [3:0]  opn;
  logic        wr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_any_act <= '1; s_mrs <= '1; opn <= '0;
      for (int i = 0; i < 4; i++) begin s_act[i] <= '1; s_wr[i] <= '1; end
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (s_act[i] != '1) s_act[i] <= s_act[i] + 1'b1;
        if (s_wr[i]  != '1) s_wr[i]  <= s_wr[i]  + 1'b1;
      end
      if (s_any_act != '1) s_any_act <= s_any_act + 1'b1;
      if (s_mrs != '1)     s_mrs     <= s_mrs + 1'b1;
      if (is_act) begin s_act[ba] <= 16'd1; s_any_act <= 16'd1; opn[ba] <= 1'b1; end
      if (is_wr)  s_wr[ba] <= 16'd1;
      if (is_col && addr[10]) opn[ba] <= 1'b0;
      if (is_pre) begin
        if (addr[10]) opn <= '0;
        else          opn[ba] <= 1'b0;
      end
      if (is_mrs) s_mrs <= 16'd1;
    end
  end

  always_comb begin
    wr_ok = 1'b1;
    if (addr[10]) begin
      for (int i = 0; i < 4; i++) wr_ok = wr_ok && (s_wr[i] >= 16'(WR_CYC));
    end else wr_ok = (s_wr[ba] >= 16'(WR_CYC));
  end

  a_r1_ack_is_column: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> is_col);
  a_r2_init_holds: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r3_mode_gap: assert property (@(posedge clk) disable iff (!rst_n)
    is_any |-> (s_mrs >= 16'(MRD_CYC)));
  a_r4_act_to_col: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (s_act[ba] >= 16'(RCD)));
  a_r5_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (s_any_act >= 16'(RRD)));
  a_r6_write_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> wr_ok);
  a_r9_refresh_closed: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (opn == 4'b0000));
endmodule

bind sdram_seq sdram_seq_chk #(
  .CLK_NS(CLK_NS), .T_RCD_NS(T_RCD_NS), .T_RRD_NS(T_RRD_NS),
  .MRD_CYC(MRD_CYC), .WR_CYC(WR_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .req_ack(req_ack), .init_done(init_done)
);

// File: tb/sim_sdram_seq.sv
module sim_sdram_seq;
  localparam int CK   = 5;
  localparam int RCD  = (20 + CK - 1) / CK;
  localparam int RP   = (20 + CK - 1) / CK;
  localparam int RAS  = (45 + CK - 1) / CK;
  localparam int RC   = (70 + CK - 1) / CK;
  localparam int RRD  = (20 + CK - 1) / CK;
  localparam int MRD  = 2;
  localparam int WR   = 2;
  localparam int REFI = 64_000_000 / 4096 / CK;

  // {write, bank[1:0], row[11:0], col[8:0], auto-precharge}
  localparam logic [24:0] VEC [12] = '{
    {1'b1, 2'd0, 12'd5, 9'd1,   1'b0},
    {1'b0, 2'd0, 12'd5, 9'd2,   1'b0},
    {1'b1, 2'd1, 12'd7, 9'd3,   1'b0},
    {1'b0, 2'd0, 12'd9, 9'd4,   1'b0},
    {1'b1, 2'd2, 12'd1, 9'd5,   1'b1},
    {1'b0, 2'd2, 12'd1, 9'd6,   1'b0},
    {1'b1, 2'd3, 12'd2, 9'd7,   1'b0},
    {1'b0, 2'd3, 12'd2, 9'd8,   1'b1},
    {1'b1, 2'd3, 12'd2, 9'd9,   1'b0},
    {1'b1, 2'd1, 12'd7, 9'd10,  1'b0},
    {1'b1, 2'd1, 12'd8, 9'd11,  1'b0},
    {1'b0, 2'd0, 12'd9, 9'd511, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
  logic [1:0] req_bank = '0;
  logic [11:0] req_row = '0;
  logic [8:0] req_col = '0;
  logic req_ack, init_done, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [11:0] addr;
  wire [3:0] cmd = {cs_n, ras_n, cas_n, we_n};

  int checks = 0, fails = 0, cyc = 0;
  int t_act [4] = '{-1000, -1000, -1000, -1000};
  int t_wr [4]  = '{-1000, -1000, -1000, -1000};
  int t_free [4] = '{-1000, -1000, -1000, -1000};
  int n_act [4] = '{0, 0, 0, 0};
  int n_pre [4] = '{0, 0, 0, 0};
  bit mon_open [4] = '{0, 0, 0, 0};
  int t_act_any = -1000, t_mrs = -1000, t_ref = -1000, t_ref_prev = -1000;
  int n_pall = 0, n_ref = 0, t_pall_first = -1;
  logic [11:0] mrs_addr = '0;
  logic [1:0] mrs_ba = 2'd3;
  bit m_open [4] = '{0, 0, 0, 0};
  logic [11:0] m_row [4];

  sdram_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ap(req_ap), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_ack(req_ack), .init_done(init_done), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(negedge clk) begin
    int b;
    if (rst_n && !cs_n && cmd != 4'b0111) begin
      b = int'(ba);
      chk(cyc - t_mrs >= MRD, "R3 gap after mode set", cyc - t_mrs, MRD);
      chk(cyc - t_ref >= RC, "R9 gap after refresh", cyc - t_ref, RC);
      case (cmd)
        4'b0011: begin
          chk(cyc - t_act_any >= RRD, "R5 activate spacing across banks", cyc - t_act_any, RRD);
          chk(cyc - t_act[b] >= RC, "R5 activate spacing same bank", cyc - t_act[b], RC);
          chk(cyc >= t_free[b], "R5 precharge to activate", cyc, t_free[b]);
          chk(!mon_open[b], "R8 activate only on closed bank", int'(mon_open[b]), 0);
          t_act[b] = cyc; t_act_any = cyc; mon_open[b] = 1'b1; n_act[b]++;
        end
        4'b0101, 4'b0100: begin
          chk(cyc - t_act[b] >= RCD, "R4 activate to column", cyc - t_act[b], RCD);
          chk(mon_open[b], "R7 column to open bank", int'(mon_open[b]), 1);
          if (!we_n) t_wr[b] = cyc;
          if (addr[10]) begin
            mon_open[b] = 1'b0;
            t_free[b] = cyc + RP + (!we_n ? WR : 1);
          end
        end
        4'b0010: begin
          if (addr[10]) begin
            if (n_pall == 0) t_pall_first = cyc;
            n_pall++;
            for (int i = 0; i < 4; i++) begin
              if (mon_open[i]) begin
                chk(cyc - t_act[i] >= RAS, "R6 active time before precharge-all", cyc - t_act[i], RAS);
                chk(cyc - t_wr[i] >= WR, "R6 write recovery before precharge-all", cyc - t_wr[i], WR);
              end
              mon_open[i] = 1'b0;
              if (t_free[i] < cyc + RP) t_free[i] = cyc + RP;
            end
          end else begin
            chk(cyc - t_act[b] >= RAS, "R6 active time before precharge", cyc - t_act[b], RAS);
            chk(cyc - t_wr[b] >= WR, "R6 write recovery before precharge", cyc - t_wr[b], WR);
            mon_open[b] = 1'b0; t_free[b] = cyc + RP; n_pre[b]++;
          end
        end
        4'b0001: begin
          for (int i = 0; i < 4; i++) begin
            chk(!mon_open[i], "R9 refresh with banks closed", int'(mon_open[i]), 0);
            chk(cyc >= t_free[i], "R9 refresh after precharge time", cyc, t_free[i]);
          end
          n_ref++; t_ref_prev = t_ref; t_ref = cyc;
        end
        4'b0000: begin
          t_mrs = cyc; mrs_addr = addr; mrs_ba = ba;
        end
        default: chk(1'b0, "R1 unknown command code", int'(cmd), 7);
      endcase
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int t_rel;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R2 deselect during reset", int'(cs_n), 1);
    chk(req_ack == 1'b0, "R2 no acknowledge during reset", int'(req_ack), 0);
    chk(init_done == 1'b0, "R2 init_done low during reset", int'(init_done), 0);
    rst_n = 1'b1;
    t_rel = cyc;
    repeat (RP + MRD + 2) @(negedge clk);
    #1;
    chk(t_pall_first == t_rel + 1, "R2 first command is precharge-all", t_pall_first, t_rel + 1);
    chk(t_mrs == t_rel + 1 + RP, "R3 mode set after precharge time", t_mrs, t_rel + 1 + RP);
    chk(mrs_addr == 12'h030, "R3 mode register value", int'(mrs_addr), 'h030);
    chk(mrs_ba == 2'd0, "R3 mode set bank", int'(mrs_ba), 0);
    chk(init_done == 1'b1, "R2 init_done after mode set", int'(init_done), 1);

    for (int k = 0; k < 12; k++) begin
      logic [24:0] v;
      int bk, a0, p0, r0;
      bit hit, miss;
      v = VEC[k];
      bk = int'(v[23:22]);
      a0 = n_act[bk]; p0 = n_pre[bk]; r0 = n_ref;
      hit  = m_open[bk] && (m_row[bk] == v[21:10]);
      miss = m_open[bk] && !hit;
      req_valid = 1'b1; req_write = v[24]; req_bank = v[23:22];
      req_row = v[21:10]; req_col = v[9:1]; req_ap = v[0];
      do begin @(negedge clk); #1; end while (!req_ack);
      chk(cmd == (v[24] ? 4'b0100 : 4'b0101), "R1 column command code", int'(cmd), v[24] ? 4 : 5);
      chk(ba == v[23:22], "R4 column bank", int'(ba), bk);
      chk(addr[8:0] == v[9:1], "R4 column address", int'(addr[8:0]), int'(v[9:1]));
      chk(addr[10] == v[0], "R10 auto-precharge flag", int'(addr[10]), int'(v[0]));
      if (n_ref == r0) begin
        chk(n_act[bk] - a0 == (hit ? 0 : 1),
            hit ? "R7 open row needs no activate" : (miss ? "R8 row miss activates once" : "R10 closed bank activates once"),
            n_act[bk] - a0, hit ? 0 : 1);
        chk(n_pre[bk] - p0 == (miss ? 1 : 0),
            miss ? "R8 row miss precharges once" : "R7 no precharge without row miss",
            n_pre[bk] - p0, miss ? 1 : 0);
      end
      m_open[bk] = !v[0];
      m_row[bk] = v[21:10];
      if (k == 11) req_valid = 1'b0;
    end

    repeat (2) @(negedge clk);
    #1;
    chk(cmd == 4'b0111, "R1 idle drives no-operation", int'(cmd), 7);
    chk(req_ack == 1'b0, "R1 no acknowledge when idle", int'(req_ack), 0);

    while (n_ref < 1) @(negedge clk);
    #1;
    chk(n_pall >= 2, "R9 precharge-all closes open banks before refresh", n_pall, 2);
    while (n_ref < 3) @(negedge clk);
    #1;
    chk(t_ref - t_ref_prev == REFI, "R9 idle refresh interval", t_ref - t_ref_prev, REFI);

    begin
      int a0, p0;
      a0 = n_act[0]; p0 = n_pre[0];
      req_valid = 1'b1; req_write = 1'b0; req_bank = 2'd0;
      req_row = 12'd9; req_col = 9'd3; req_ap = 1'b0;
      do begin @(negedge clk); #1; end while (!req_ack);
      req_valid = 1'b0;
      chk(n_act[0] - a0 == 1, "R9 bank closed by refresh needs activate", n_act[0] - a0, 1);
      chk(n_pre[0] - p0 == 0, "R9 no precharge after refresh", n_pre[0] - p0, 0);
      chk(t_act[0] - t_ref >= RC, "R9 activate waits row cycle after refresh", t_act[0] - t_ref, RC);
    end

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule